// File: doc/BRIEF.md
# Latched Fault Status and Attention Controller

This block gathers eight condition inputs from a flash LED driver into one status byte. Each bit has its own policy. Two bits (flash running and over-current) follow their inputs cycle by cycle. The other six are sticky: once set, they stay set until software reads the status byte or the device drops into shutdown. Four of the sticky conditions are severe and raise a request that returns the power stage to its idle ready state.

The controller also drives an active-low attention line toward the host. The line is low while any sticky bit is held. It is also low for a fixed number of clock cycles after a flash-timer expiry request. While any sticky bit is held, a lock flag tells the register file to keep the trigger-enable, torch-on and auxiliary LED fields unchanged. Threshold comparators sit outside the block, so every condition arrives as a digital level.

Top module: `stat_attn_ctrl`

## Requirements
- R1: `stat_o` bit positions are fixed: bit 7 LED short, bit 6 flash running, bit 5 LED fault, bit 4 thermistor warm, bit 3 thermistor hot, bit 2 over-temperature, bit 1 over-current, bit 0 output not OK. `cond_i` uses the same positions, and an asserted condition appears in `stat_o` one clock later.
- R2: Bits 6 and 1 are live. Each equals its `cond_i` bit from the previous cycle and never holds a stale 1.
- R3: Bits 7, 5, 4, 3, 2 and 0 are sticky. Once set, a bit stays 1 after its condition drops, as long as no read and no shutdown occurs.
- R4: A cycle with `stat_rd_i` high clears every sticky bit on the next clock. The exception is a bit whose condition is still high in that same cycle: that bit stays 1.
- R5: `force_rdy_o` is high exactly while any of bits 5, 3, 2 or 0 is set. Bits 7 and 4 on their own leave it low.
- R6: `attn_n_o` is low in every cycle in which any sticky bit of `stat_o` is 1.
- R7: A `tmo_i` cycle drives `attn_n_o` low for exactly PULSE_CYC cycles, starting on the next clock. A new request during the pulse restarts the count.
- R8: `lock_o` is high exactly while any sticky bit is set.
- R9: A cycle with `sdn_i` high clears all status bits and any running timeout pulse on the next clock. It overrides conditions, reads and timeout requests in that cycle.
- R10: After reset, `stat_o` is 0, `attn_n_o` is 1, and `force_rdy_o` and `lock_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 8 | Condition levels, one per status bit position |
| stat_rd_i | input | 1 | One-cycle strobe: status byte read by host |
| tmo_i | input | 1 | One-cycle flash-timer expiry request |
| sdn_i | input | 1 | Shutdown entry: clear all status |
| stat_o | output | 8 | Status byte |
| attn_n_o | output | 1 | Active-low attention to host |
| force_rdy_o | output | 1 | Request to force the power stage to ready |
| lock_o | output | 1 | Control fields frozen while high |

## Verification
The assertions assume that the read, timeout and shutdown strobes are sampled as levels on each clock. They also assume that conditions may change in any cycle, including the cycle of a read or a shutdown. The stimulus draws condition bytes with varied densities and raises the strobes at low, independent rates. It regularly produces reads that coincide with active conditions, timeout requests during a running pulse, and shutdowns that collide with reads. Directed sequences cover reset, sticky hold, read-versus-condition collision, pulse length and retrigger, and the non-forcing bits on their own.

// File: rtl/stat_attn_pkg.sv
package stat_attn_pkg;
    localparam int NBITS = 8;

    // bit positions of the status byte (decoded by host software)
    localparam int B_LED_SHORT = 7;
    localparam int B_FLASH_RUN = 6;
    localparam int B_LED_FAULT = 5;
    localparam int B_NTC_WARM  = 4;
    localparam int B_NTC_HOT   = 3;
    localparam int B_OVER_TEMP = 2;
    localparam int B_OVER_CURR = 1;
    localparam int B_VOUT_BAD  = 0;

    // per-bit policies
    localparam logic [NBITS-1:0] STICKY_MASK =
        (NBITS'(1) << B_LED_SHORT) | (NBITS'(1) << B_LED_FAULT) |
        (NBITS'(1) << B_NTC_WARM)  | (NBITS'(1) << B_NTC_HOT)   |
        (NBITS'(1) << B_OVER_TEMP) | (NBITS'(1) << B_VOUT_BAD);
    localparam logic [NBITS-1:0] FORCE_MASK =
        (NBITS'(1) << B_LED_FAULT) | (NBITS'(1) << B_NTC_HOT) |
        (NBITS'(1) << B_OVER_TEMP) | (NBITS'(1) << B_VOUT_BAD);
endpackage

// File: rtl/stat_bit_bank.sv
module stat_bit_bank
    import stat_attn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] cond_i,
    input  logic             rd_i,
    input  logic             clr_i,
    output logic [NBITS-1:0] stat_o
);
    typedef struct packed {
        logic [NBITS-1:0] stat;
    } bank_t;

    bank_t            st_d, st_q;
    logic [NBITS-1:0] bit_nxt;

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        if (STICKY_MASK[b]) begin : g_sticky
            // a read drops the bit unless its condition is present now
            always_comb begin
                if (clr_i)     bit_nxt[b] = 1'b0;
                else if (rd_i) bit_nxt[b] = cond_i[b];
                else           bit_nxt[b] = st_q.stat[b] | cond_i[b];
            end
        end else begin : g_live
            always_comb bit_nxt[b] = clr_i ? 1'b0 : cond_i[b];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    assert_live_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_o & ~STICKY_MASK) == ($past(cond_i) & ~STICKY_MASK)));

    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rd_i) |=> ((stat_o & $past(stat_o) & STICKY_MASK) == ($past(stat_o) & STICKY_MASK)));

    assert_read_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !clr_i) |=> ((stat_o & STICKY_MASK) == ($past(cond_i) & STICKY_MASK)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (stat_o == '0));
endmodule

// File: rtl/attn_pulse_gen.sv
module attn_pulse_gen #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic clr_i,
    output logic active_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pls_t;

    pls_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)                 st_d.cnt = '0;
        else if (trig_i)           st_d.cnt = CW'(PULSE_CYC);
        else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !clr_i) |=> active_o);

    assert_pulse_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !active_o);
endmodule

// File: rtl/stat_attn_ctrl.sv
module stat_attn_ctrl
    import stat_attn_pkg::*;
#(
    parameter int PULSE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] cond_i,
    input  logic             stat_rd_i,
    input  logic             tmo_i,
    input  logic             sdn_i,
    output logic [NBITS-1:0] stat_o,
    output logic             attn_n_o,
    output logic             force_rdy_o,
    output logic             lock_o
);
    logic [NBITS-1:0] stat_w;
    logic             pulse_w;
    logic             held_w;

    stat_bit_bank i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_i),
        .rd_i   (stat_rd_i),
        .clr_i  (sdn_i),
        .stat_o (stat_w)
    );

    attn_pulse_gen #(.PULSE_CYC(PULSE_CYC)) i_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (tmo_i),
        .clr_i    (sdn_i),
        .active_o (pulse_w)
    );

    always_comb begin
        held_w      = |(stat_w & STICKY_MASK);
        stat_o      = stat_w;
        lock_o      = held_w;
        force_rdy_o = |(stat_w & FORCE_MASK);
        attn_n_o    = ~(held_w | pulse_w);
    end

    assert_attn_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_o & STICKY_MASK)) |-> !attn_n_o);

    assert_force_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_rdy_o |-> lock_o);

    assert_lock_attn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !attn_n_o);

    assert_timeout_attn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_i && !sdn_i) |=> !attn_n_o);
endmodule

// File: tb/test_stat_attn_ctrl.sv
module test_stat_attn_ctrl;
    localparam int P = 8;
    localparam logic [7:0] STK = 8'b1011_1101;
    localparam logic [7:0] FRC = 8'b0010_1101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cond = '0;
    logic       rd = 1'b0, tmo = 1'b0, sdn = 1'b0;
    logic [7:0] stat;
    logic       attn_n, frc, lck;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_stat = '0;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    stat_attn_ctrl #(.PULSE_CYC(P)) i_stat_attn_ctrl (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .stat_rd_i(rd),
        .tmo_i(tmo), .sdn_i(sdn), .stat_o(stat), .attn_n_o(attn_n),
        .force_rdy_o(frc), .lock_o(lck)
    );

    function automatic logic [7:0] nxt_stat(logic [7:0] s, logic [7:0] c, logic r, logic z);
        if (z) return 8'h00;
        if (r) return c;
        return ((s | c) & STK) | (c & ~STK);
    endfunction

    function automatic int nxt_cnt(int n, logic t, logic z);
        if (z) return 0;
        if (t) return P;
        return (n > 0) ? n - 1 : 0;
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic held;
        held = |(m_stat & STK);
        chk(tag, "stat", stat, m_stat);
        chk(tag, "attn_n", {7'd0, attn_n}, {7'd0, ~(held | (m_cnt > 0))});
        chk(tag, "force", {7'd0, frc}, {7'd0, |(m_stat & FRC)});
        chk(tag, "lock", {7'd0, lck}, {7'd0, held});
    endtask

    // drive at negedge, model the coming posedge, check at next negedge
    task automatic step(string tag, logic [7:0] c, logic r, logic t, logic z);
        cond = c; rd = r; tmo = t; sdn = z;
        m_stat = nxt_stat(m_stat, c, r, z);
        m_cnt  = nxt_cnt(m_cnt, t, z);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_all("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10");

        // R1: each condition bit lands in its own position
        for (int b = 0; b < 8; b++) begin
            step("R1", 8'h01 << b, 1'b0, 1'b0, 1'b0);
            step("R9", 8'h00, 1'b0, 1'b0, 1'b1);
        end

        // R2: live bits drop when conditions drop
        step("R2", 8'b0100_0010, 0, 0, 0);
        step("R2", 8'h00, 0, 0, 0);

        // R3: sticky hold; R5 non-forcing bits alone
        step("R3", 8'b1001_0000, 0, 0, 0);
        step("R3", 8'h00, 0, 0, 0);
        step("R5", 8'h00, 0, 0, 0);
        step("R3", 8'b0000_1000, 0, 0, 0);
        step("R8", 8'h00, 0, 0, 0);

        // R4: read with a condition still present keeps that bit
        step("R4", 8'b0000_0100, 1, 0, 0);
        step("R4", 8'h00, 1, 0, 0);
        step("R6", 8'h00, 0, 0, 0);

        // R7: pulse length and retrigger
        step("R7", 8'h00, 0, 1, 0);
        for (int i = 0; i < P + 2; i++) step("R7", 8'h00, 0, 0, 0);
        step("R7", 8'h00, 0, 1, 0);
        step("R7", 8'h00, 0, 0, 0);
        step("R7", 8'h00, 0, 0, 0);
        step("R7", 8'h00, 0, 1, 0);
        for (int i = 0; i < P + 2; i++) step("R7", 8'h00, 0, 0, 0);

        // R9: shutdown beats condition, read and timeout together
        step("R9", 8'hFF, 0, 1, 0);
        step("R9", 8'hFF, 1, 1, 1);
        step("R9", 8'h00, 0, 0, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] c;
            int dens;
            dens = $urandom_range(0, 3);
            c = 8'($urandom);
            if (dens == 0) c = c & 8'($urandom) & 8'($urandom);
            else if (dens == 1) c = 8'h00;
            step("R1", c, ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 31) == 0));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule